// File: doc/BRIEF.md
# Two-Rate Three-Color Packet Policer

This block meters ingress packets against two token buckets and marks each one green, yellow or red. One bucket holds the committed rate and the other the peak rate. For each color a configurable action decides whether the packet passes or is dropped. Bucket fill rates, bucket depths and the per-packet adjustment are all coded as a mantissa/exponent pair. Such a pair is worth (1 + M/256)·2^E tokens, and one token is one byte. Levels are kept in fixed point with 8 fractional bits, so the smallest charge is 1/256 of a token.

A free-running time base makes a refill tick every `TICK_CYCLES`·2^`tick_div` clock cycles. `TICK_CYCLES` is the number of clocks in one base time unit. A packet is presented as a length, an optional pre-color and a valid strobe. The verdict (color and drop flag) comes out registered one clock later. A packet-count mode charges a fixed adjust cost per packet instead of the byte length, so the same hardware can limit packets per second. Setting a bucket's depth exponent to 24 or more makes that bucket zero-sized. Switching off the peak bucket this way turns the meter into a green/red marker.

Top module: `trtcm_policer`

## Requirements
- R1: For every clock edge where `pkt_valid` is high, `res_valid` is high exactly one edge later with that packet's verdict. `res_valid` is low after every edge where `pkt_valid` was low.
- R2: While `rst` is high, `res_valid` is held low and both buckets are loaded to their configured depth. A first packet whose cost equals the committed depth is therefore green.
- R3: A refill happens at clock edge n (n = 1 is the first edge with `rst` low) whenever n is a multiple of `TICK_CYCLES`·2^`tick_div`. Each bucket then gains (256+M)·2^E/256 tokens from its rate pair. The level saturates at the bucket depth and never rises between refills.
- R4: A bucket depth is (256+M)·2^E/256 tokens from its burst pair. Any exponent of 24 or more, for a rate or for a depth, gives zero.
- R5: In byte mode (`count_packets`=0), the cost is max((len − `len_offset`) + (`adj_mant`/256 − 1)·2^`adj_exp`, 1/256) tokens, with the subtraction signed.
- R6: In packet mode (`count_packets`=1), the length term is zero. With `adj_mant`=384 and `adj_exp`=1, every packet costs exactly one token.
- R7: Color codes are green=0, yellow=1, red=2. The result is red if the peak bucket holds less than the cost, otherwise yellow if the committed bucket holds less than the cost, otherwise green. Green debits both buckets, yellow debits only the peak bucket, red debits neither.
- R8: When the peak depth exponent is 24 or more, the peak bucket is bypassed. A packet is green if the committed bucket covers it (debiting only that bucket), else red. Yellow never occurs.
- R9: `color_mode`=3 is color-blind: `pkt_color` has no effect on the verdict or on the buckets.
- R10: Any other `color_mode` is color-aware. A pre-color of 2 or 3 gives red with no debit. A pre-color of 1 never yields green: the packet is red if the peak bucket cannot cover it, else yellow.
- R11: `res_drop` is 1 exactly when the 2-bit action field for the result color equals 1. Codes 0, 2 and 3 pass.
- R12: A refill falling on the same edge as a packet is added before that packet is metered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_rate_mant | input | 8 | Committed refill mantissa |
| commit_rate_exp | input | 5 | Committed refill exponent |
| commit_burst_mant | input | 8 | Committed depth mantissa |
| commit_burst_exp | input | 5 | Committed depth exponent |
| peak_rate_mant | input | 8 | Peak refill mantissa |
| peak_rate_exp | input | 5 | Peak refill exponent |
| peak_burst_mant | input | 8 | Peak depth mantissa |
| peak_burst_exp | input | 5 | Peak depth exponent (24 or more bypasses the peak bucket) |
| tick_div | input | 4 | Refill period is TICK_CYCLES·2^tick_div clocks |
| count_packets | input | 1 | 1: charge adjust cost only; 0: charge bytes plus adjust |
| len_offset | input | OFF_W | Bytes subtracted from the length in byte mode |
| adj_mant | input | 9 | Per-packet adjust mantissa |
| adj_exp | input | 5 | Per-packet adjust exponent |
| color_mode | input | 2 | 3: color-blind; other values: color-aware |
| act_green | input | 2 | Action for green (1 = drop) |
| act_yellow | input | 2 | Action for yellow (1 = drop) |
| act_red | input | 2 | Action for red (1 = drop) |
| pkt_valid | input | 1 | Packet strobe |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_color | input | 2 | Pre-color in color-aware mode |
| res_valid | output | 1 | Verdict strobe |
| res_color | output | 2 | Verdict color |
| res_drop | output | 1 | Verdict drop flag |

## Verification
The bench exercises the exact-fit edge: a cost equal to the level must pass, and an off-by-one compare would turn the first full-depth packet yellow. It makes packets arrive on the refill edge and holds long idle gaps. A design that refilled after metering, or failed to saturate at the depth, would then recolor later packets. A negative length term must still cost 1/256, and a fractional adjust must cost the right amount. The packet-count mode has to yield exactly four green packets from a four-token bucket. A bypassed peak bucket must never produce yellow, and a design that kept charging it would turn everything red. A blind meter must ignore a red pre-color, while an aware one must honor it. Each action code is driven, so a drop decoder that looked at one bit would be caught on codes 2 and 3.

// File: rtl/policer_pkg.sv
package policer_pkg;

    localparam int FRAC_W     = 8;
    localparam int ZERO_EXP   = 24;
    localparam int LVL_W      = 32;
    localparam int COST_W     = 48;
    localparam int MANT_W     = 8;
    localparam int EXP_W      = 5;
    localparam int ADJ_M_W    = 9;
    localparam int ADJ_UNITY  = 256;
    localparam int NUM_BKT    = 2;
    localparam int BKT_COMMIT = 0;
    localparam int BKT_PEAK   = 1;

    localparam logic [1:0] ACT_DROP   = 2'd1;
    localparam logic [1:0] MODE_BLIND = 2'd3;

    typedef enum logic [1:0] {
        CLR_GREEN  = 2'd0,
        CLR_YELLOW = 2'd1,
        CLR_RED    = 2'd2
    } color_e;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } mexp_t;

    typedef struct packed {
        logic   valid;
        color_e color;
        logic   drop;
    } verdict_t;

    // Amount in 1/256 token units: (256 + M) << E, zero for a reserved exponent.
    function automatic logic [LVL_W-1:0] mexp_value(input mexp_t v);
        logic [LVL_W-1:0] base;
        base = LVL_W'({1'b1, v.mant});
        if (v.expo >= EXP_W'(ZERO_EXP)) return '0;
        return base << v.expo;
    endfunction

    function automatic color_e to_color(input logic [1:0] code);
        case (code)
            2'd0:    return CLR_GREEN;
            2'd1:    return CLR_YELLOW;
            default: return CLR_RED;
        endcase
    endfunction

endpackage

// File: rtl/pol_tick_gen.sv
module pol_tick_gen
    import policer_pkg::*;
#(
    parameter int TICK_CYCLES = 200,
    parameter int DIV_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] rdiv,
    output logic             tick
);
    localparam int BASE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int DCNT_W = (1 << DIV_W) - 1;
    localparam int GAP_W  = BASE_W + 1;

    logic [BASE_W-1:0] base_q;
    logic [DCNT_W-1:0] div_q;
    logic [DCNT_W-1:0] div_last;
    logic              base_end;

    assign base_end = (base_q == BASE_W'(TICK_CYCLES - 1));
    assign div_last = (DCNT_W'(1) << rdiv) - DCNT_W'(1);
    assign tick     = base_end && (div_q == div_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            div_q  <= '0;
        end else begin
            base_q <= base_end ? '0 : base_q + 1'b1;
            if (base_end) div_q <= (div_q == div_last) ? '0 : div_q + 1'b1;
        end
    end

    // Checker: refill ticks are never closer than one base time unit.
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q < GAP_W'(TICK_CYCLES)) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && seen_q) |-> (gap_q >= GAP_W'(TICK_CYCLES - 1)));

endmodule

// File: rtl/pol_cost.sv
module pol_cost
    import policer_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int OFF_W = 8
) (
    input  logic [LEN_W-1:0]   len,
    input  logic [OFF_W-1:0]   len_off,
    input  logic               count_pkts,
    input  logic [ADJ_M_W-1:0] adj_mant,
    input  logic [EXP_W-1:0]   adj_exp,
    output logic [COST_W-1:0]  cost
);
    logic signed [COST_W-1:0] len_term;
    logic signed [COST_W-1:0] adj_term;
    logic signed [COST_W-1:0] total;

    always_comb begin
        len_term = count_pkts ? '0
                 : ($signed(COST_W'(len)) - $signed(COST_W'(len_off))) <<< FRAC_W;
        adj_term = ($signed(COST_W'(adj_mant)) - $signed(COST_W'(ADJ_UNITY))) <<< adj_exp;
        total    = len_term + adj_term;
        cost     = (total <= 0) ? COST_W'(1) : COST_W'(total);
    end

endmodule

// File: rtl/pol_bucket.sv
module pol_bucket
    import policer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  mexp_t             rate_cfg,
    input  mexp_t             burst_cfg,
    input  logic              debit_en,
    input  logic [COST_W-1:0] cost,
    output logic [LVL_W-1:0]  level_eff
);
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] add;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] lvl_d;
    logic [LVL_W:0]   grown;

    assign cap = mexp_value(burst_cfg);
    assign add = mexp_value(rate_cfg);

    // Refill (and clamp to depth) first; the packet sees the refilled level.
    always_comb begin
        grown     = {1'b0, lvl_q} + (tick ? {1'b0, add} : '0);
        level_eff = (grown > {1'b0, cap}) ? cap : grown[LVL_W-1:0];
        lvl_d     = debit_en ? level_eff - cost[LVL_W-1:0] : level_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= cap;
        else     lvl_q <= lvl_d;
    end

    assert_debit_covered_R7: assert property (@(posedge clk) disable iff (rst)
        debit_en |-> (COST_W'(level_eff) >= cost));

    assert_level_capped_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lvl_q <= $past(cap)));

    assert_no_gain_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (lvl_q <= $past(lvl_q)));

endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer
    import policer_pkg::*;
#(
    parameter int TICK_CYCLES = 200,
    parameter int LEN_W       = 16,
    parameter int OFF_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       commit_rate_mant,
    input  logic [4:0]       commit_rate_exp,
    input  logic [7:0]       commit_burst_mant,
    input  logic [4:0]       commit_burst_exp,
    input  logic [7:0]       peak_rate_mant,
    input  logic [4:0]       peak_rate_exp,
    input  logic [7:0]       peak_burst_mant,
    input  logic [4:0]       peak_burst_exp,
    input  logic [3:0]       tick_div,
    input  logic             count_packets,
    input  logic [OFF_W-1:0] len_offset,
    input  logic [8:0]       adj_mant,
    input  logic [4:0]       adj_exp,
    input  logic [1:0]       color_mode,
    input  logic [1:0]       act_green,
    input  logic [1:0]       act_yellow,
    input  logic [1:0]       act_red,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [1:0]       pkt_color,
    output logic             res_valid,
    output logic [1:0]       res_color,
    output logic             res_drop
);
    logic              tick;
    logic [COST_W-1:0] cost;
    mexp_t             rate_cfg  [NUM_BKT];
    mexp_t             burst_cfg [NUM_BKT];
    logic              debit     [NUM_BKT];
    logic              covers    [NUM_BKT];
    logic [LVL_W-1:0]  lvl_eff   [NUM_BKT];
    logic              peak_off;
    color_e            pre;
    verdict_t          v_d, v_q;
    logic [1:0]        act_sel;

    assign rate_cfg[BKT_COMMIT]  = '{mant: commit_rate_mant,  expo: commit_rate_exp};
    assign burst_cfg[BKT_COMMIT] = '{mant: commit_burst_mant, expo: commit_burst_exp};
    assign rate_cfg[BKT_PEAK]    = '{mant: peak_rate_mant,    expo: peak_rate_exp};
    assign burst_cfg[BKT_PEAK]   = '{mant: peak_burst_mant,   expo: peak_burst_exp};

    pol_tick_gen #(.TICK_CYCLES(TICK_CYCLES), .DIV_W(4)) u_tick (
        .clk (clk), .rst (rst), .rdiv (tick_div), .tick (tick)
    );

    pol_cost #(.LEN_W(LEN_W), .OFF_W(OFF_W)) u_cost (
        .len (pkt_len), .len_off (len_offset), .count_pkts (count_packets),
        .adj_mant (adj_mant), .adj_exp (adj_exp), .cost (cost)
    );

    for (genvar b = 0; b < NUM_BKT; b++) begin : g_bucket
        pol_bucket u_bkt (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .rate_cfg  (rate_cfg[b]),
            .burst_cfg (burst_cfg[b]),
            .debit_en  (debit[b]),
            .cost      (cost),
            .level_eff (lvl_eff[b])
        );
        assign covers[b] = (cost <= COST_W'(lvl_eff[b]));
    end

    assign peak_off = (peak_burst_exp >= 5'(ZERO_EXP));

    always_comb begin
        pre = (color_mode == MODE_BLIND) ? CLR_GREEN : to_color(pkt_color);
        v_d.valid = pkt_valid;
        if (pre == CLR_RED)                            v_d.color = CLR_RED;
        else if (peak_off)                             v_d.color = (pre == CLR_GREEN && covers[BKT_COMMIT]) ? CLR_GREEN : CLR_RED;
        else if (!covers[BKT_PEAK])                    v_d.color = CLR_RED;
        else if (pre == CLR_YELLOW || !covers[BKT_COMMIT]) v_d.color = CLR_YELLOW;
        else                                           v_d.color = CLR_GREEN;
        case (v_d.color)
            CLR_GREEN:  act_sel = act_green;
            CLR_YELLOW: act_sel = act_yellow;
            default:    act_sel = act_red;
        endcase
        v_d.drop          = (act_sel == ACT_DROP);
        debit[BKT_COMMIT] = pkt_valid && (v_d.color == CLR_GREEN);
        debit[BKT_PEAK]   = pkt_valid && !peak_off && (v_d.color != CLR_RED);
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= '{valid: 1'b0, color: CLR_GREEN, drop: 1'b0};
        else     v_q <= v_d;
    end

    assign res_valid = v_q.valid;
    assign res_color = v_q.color;
    assign res_drop  = v_q.drop;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> res_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> !res_valid);

    assert_peak_off_no_yellow_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && peak_burst_exp >= 5'(ZERO_EXP)) |=> (res_color != 2'd1));

    assert_prered_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && color_mode != MODE_BLIND && pkt_color[1]) |=> (res_color == 2'd2));

    assert_action_R11: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> (res_drop == (((res_color == 2'd0) ? $past(act_green)
                                   : (res_color == 2'd1) ? $past(act_yellow)
                                   : $past(act_red)) == ACT_DROP)));

endmodule

// File: tb/trtcm_policer_tb_top.sv
module trtcm_policer_tb_top;
    localparam int TB_TICK = 4;
    localparam int LEN_W   = 16;
    localparam int OFF_W   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] c_rm, c_bm, p_rm, p_bm;
    logic [4:0] c_re, c_be, p_re, p_be;
    logic [3:0] rdiv;
    logic       lmode;
    logic [OFF_W-1:0] off;
    logic [8:0] adjm;
    logic [4:0] adje;
    logic [1:0] mode, ag, ay, ar;
    logic       pkt_valid = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [1:0] pkt_color = 2'd0;
    logic       res_valid;
    logic [1:0] res_color;
    logic       res_drop;

    always #5 clk = ~clk;

    trtcm_policer #(.TICK_CYCLES(TB_TICK), .LEN_W(LEN_W), .OFF_W(OFF_W)) dut_i (
        .clk (clk), .rst (rst),
        .commit_rate_mant (c_rm), .commit_rate_exp (c_re),
        .commit_burst_mant (c_bm), .commit_burst_exp (c_be),
        .peak_rate_mant (p_rm), .peak_rate_exp (p_re),
        .peak_burst_mant (p_bm), .peak_burst_exp (p_be),
        .tick_div (rdiv), .count_packets (lmode), .len_offset (off),
        .adj_mant (adjm), .adj_exp (adje), .color_mode (mode),
        .act_green (ag), .act_yellow (ay), .act_red (ar),
        .pkt_valid (pkt_valid), .pkt_len (pkt_len), .pkt_color (pkt_color),
        .res_valid (res_valid), .res_color (res_color), .res_drop (res_drop)
    );

    typedef struct {
        int    color;
        bit    drop;
        int    edge_no;
        string req;
    } exp_t;

    exp_t   expq[$];
    int     checks = 0;
    int     errors = 0;
    int     edge_cnt = 0;
    longint lvl_c, lvl_p;
    string  tag = "R2";

    always @(posedge clk) edge_cnt <= rst ? 0 : edge_cnt + 1;

    function automatic longint amount(input int m, input int e);
        if (e >= 24) return 0;
        return longint'(256 + m) << e;
    endfunction

    function automatic longint refill(input longint l, input longint add, input longint cap, input bit t);
        longint v;
        v = t ? l + add : l;
        return (v > cap) ? cap : v;
    endfunction

    // Driver: called at a negedge, drives one cycle and predicts its outcome.
    task automatic step(input bit v, input int len, input int pc);
        int     n;
        bit     t, pk_off;
        longint ec, ep, cost;
        int     pre, col, act;
        exp_t   it;
        pkt_valid = v;
        pkt_len   = LEN_W'(len);
        pkt_color = 2'(pc);
        n  = edge_cnt + 1;
        t  = (n % (TB_TICK << int'(rdiv))) == 0;
        ec = refill(lvl_c, amount(int'(c_rm), int'(c_re)), amount(int'(c_bm), int'(c_be)), t);
        ep = refill(lvl_p, amount(int'(p_rm), int'(p_re)), amount(int'(p_bm), int'(p_be)), t);
        if (v) begin
            pk_off = (int'(p_be) >= 24);
            cost = (lmode ? 0 : longint'(len - int'(off)) * 256)
                 + (longint'(adjm) - 256) * (longint'(1) << int'(adje));
            if (cost < 1) cost = 1;
            pre = (mode == 2'd3) ? 0 : ((pc > 2) ? 2 : pc);
            if (pre == 2)        col = 2;
            else if (pk_off)     col = (pre == 0 && ec >= cost) ? 0 : 2;
            else if (ep < cost)  col = 2;
            else if (pre == 1 || ec < cost) col = 1;
            else                 col = 0;
            if (col == 0) ec -= cost;
            if (col != 2 && !pk_off) ep -= cost;
            act = (col == 0) ? int'(ag) : (col == 1) ? int'(ay) : int'(ar);
            it.color = col; it.drop = (act == 1); it.edge_no = n; it.req = tag;
            expq.push_back(it);
        end
        lvl_c = ec;
        lvl_p = ep;
        @(negedge clk);
    endtask

    task automatic send(input int len, input int pc = 0);
        step(1'b1, len, pc);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) step(1'b0, 0, 0);
    endtask

    task automatic defaults();
        c_rm = 0; c_re = 24; c_bm = 0; c_be = 6;
        p_rm = 0; p_re = 24; p_bm = 0; p_be = 7;
        rdiv = 0; lmode = 0; off = 0; adjm = 9'd256; adje = 0;
        mode = 2'd3; ag = 0; ay = 0; ar = 2'd1;
    endtask

    task automatic do_reset();
        idle(2);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d verdicts missing, expected 0", expq.size());
        end
        expq.delete();
        rst = 1'b1;
        pkt_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        lvl_c = amount(int'(c_bm), int'(c_be));
        lvl_p = amount(int'(p_bm), int'(p_be));
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2: res_valid=%b after reset, expected 0", res_valid);
        end
    endtask

    // Monitor: pops one expected verdict per result strobe.
    always @(negedge clk) begin
        exp_t e;
        if (!rst && res_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R1: res_valid=1 with no packet, expected 0");
            end else begin
                e = expq.pop_front();
                if (edge_cnt != e.edge_no) begin
                    errors++;
                    $display("FAIL R1: verdict at edge %0d, expected edge %0d", edge_cnt, e.edge_no);
                end
                checks++;
                if (int'(res_color) != e.color) begin
                    errors++;
                    $display("FAIL %s: color=%0d expected %0d (edge %0d)", e.req, res_color, e.color, edge_cnt);
                end
                checks++;
                if (res_drop != e.drop) begin
                    errors++;
                    $display("FAIL %s: drop=%b expected %b (edge %0d)", e.req, res_drop, e.drop, edge_cnt);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run still active, expected completion");
        finish_run();
    end

    initial begin
        defaults();
        @(negedge clk);
        // R2 / R7: full buckets after reset, exact fit, then yellow and red.
        tag = "R2"; do_reset(); send(64);
        tag = "R7"; send(60); send(10); send(4); send(1);

        // R3: periodic refill with divider, saturation after a long gap.
        defaults(); c_rm = 128; c_re = 2; p_re = 3; c_be = 5; p_be = 6; rdiv = 1;
        tag = "R3"; do_reset(); send(32);
        for (int i = 0; i < 30; i++) begin send(7); idle(2); end
        idle(200); send(32); send(1); send(31); send(2);

        // R12: refill on the same edge as a packet.
        defaults(); c_re = 0; p_re = 0; c_be = 1; p_be = 2;
        tag = "R12"; do_reset();
        for (int i = 0; i < 24; i++) send(1);

        // R8: peak bucket bypassed, only green or red.
        defaults(); c_re = 2; c_be = 4; p_be = 24;
        tag = "R8"; do_reset();
        for (int i = 0; i < 20; i++) send(6);
        send(3, 1);

        // R4: mantissa in depth, reserved committed exponent.
        defaults(); c_bm = 128; c_be = 4; p_be = 24;
        tag = "R4"; do_reset(); send(24); send(1);
        defaults(); c_be = 25; c_re = 0;
        do_reset(); send(1); idle(8); send(1);

        // R5: length offset, negative adjust, minimum cost, fractional adjust.
        defaults(); off = 20; adjm = 0; adje = 4;
        tag = "R5"; do_reset(); send(10); send(50); send(100); send(30); send(36);
        defaults(); adjm = 511; adje = 0; c_be = 3;
        do_reset(); send(3); send(4); send(3);

        // R6: packet-count mode, one token per packet.
        defaults(); lmode = 1; adjm = 384; adje = 1; c_be = 2; p_be = 3;
        tag = "R6"; do_reset();
        for (int i = 0; i < 10; i++) send(1500 - i * 100);

        // R9: blind mode ignores pre-color.
        defaults();
        tag = "R9"; do_reset(); send(10, 2); send(10, 1); send(10, 3); send(50, 2);

        // R10: color-aware handling of pre-colors.
        defaults(); mode = 2'd0;
        tag = "R10"; do_reset(); send(10, 2); send(10, 3); send(10, 1); send(10, 0);
        send(100, 1); send(10, 1); send(40, 0);

        // R11: every action code.
        defaults(); ag = 2'd1; ay = 2'd0; ar = 2'd2;
        tag = "R11"; do_reset(); send(64); send(60); send(10);
        defaults(); ag = 2'd3; ay = 2'd1; ar = 2'd3;
        do_reset(); send(64); send(60); send(10);

        idle(3);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d verdicts missing, expected 0", expq.size());
        end
        finish_run();
    end

endmodule